// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead Time

This block converts a single direction bit into the four gate enables of an H-bridge: upper and lower switch of leg A, upper and lower switch of leg B. Direction 1 conducts through A-upper and B-lower, and direction 0 conducts through B-upper and A-lower. A turn-on is held back by a programmable number of clock cycles, with one count for the upper switches and another for the lower switches. A turn-off takes effect on the next clock edge. This produces a dead time in each leg without any external timing network.

Two overrides sit above the dead-time logic. The disable input clears every gate. The upper-enable input, when low, clears only the upper gates, so the load current freewheels through the lower switches. When disable is released, the sequencer first drives both lower switches on together for a fixed refresh interval, then holds the upper switches off for a longer interval, and then resumes normal switching. A lower-delay code of all ones means "never": it keeps both lower switches off during normal operation, which is useful during start-up. The block also outputs a registered copy of the direction bit and a debug flag for same-leg overlap.

Top module: `fbg_bridge_sequencer`

## Requirements
- R1: From the clock edge that samples `dis` high, all four gate outputs are low and stay low while `dis` stays high.
- R2: In steady running with `hen` high and `dir` = 1, `a_hi` and `b_lo` are 1 and `a_lo` and `b_hi` are 0.
- R3: In steady running with `hen` high and `dir` = 0, `a_lo` and `b_hi` are 1 and `a_hi` and `b_lo` are 0.
- R4: While `hen` is low, `a_hi` and `b_hi` are 0 from the next edge on. The lower outputs keep following `dir` (`a_lo` when `dir` = 0, `b_lo` when `dir` = 1).
- R5: A gate whose request becomes true turns on `D`+1 cycles later, where `D` is `hs_dly` for the upper gates and `ls_dly` for the lower gates. A gate whose request becomes false is low one cycle later.
- R6: When `ls_dly` equals its all-ones code, neither lower output turns on outside the refresh pulse. The upper outputs keep working as in R5.
- R7: The first edge that samples `dis` low after it was high leaves all gates low. From the following edge, `a_lo` and `b_lo` are both 1 for exactly `REFRESH_CYC` cycles.
- R8: After a release, the upper gates stay low for the first `UPPER_HOLD_CYC` cycles of the sequence, counted from the first refresh cycle. An upper gate then turns on after its `hs_dly`+1 cycles, so its earliest rise is `UPPER_HOLD_CYC`+`hs_dly` cycles after the refresh starts.
- R9: When `hen` returns high, the upper gate selected by `dir` turns on only after `hs_dly`+1 cycles.
- R10: A `dir` change that reverts before a pending turn-on delay expires cancels that turn-on, and the count restarts from zero. The upper and lower gate of one leg are never on in the same cycle.
- R11: `shoot_flag`, which reports a same-leg upper/lower overlap, stays 0.
- R12: While `rst` is high all outputs are 0. After reset the block starts as though `dis` had just been released, so the refresh pulse comes first.
- R13: `out_dir` equals `dir` as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dis | input | 1 | Disable; high clears every gate |
| hen | input | 1 | Upper enable; low clears the upper gates |
| dir | input | 1 | Direction bit (comparator result) |
| hs_dly | input | DLY_W | Upper turn-on delay in cycles |
| ls_dly | input | DLY_W | Lower turn-on delay in cycles; all ones blocks lower turn-on |
| a_hi | output | 1 | Leg A upper gate enable |
| a_lo | output | 1 | Leg A lower gate enable |
| b_hi | output | 1 | Leg B upper gate enable |
| b_lo | output | 1 | Leg B lower gate enable |
| out_dir | output | 1 | Registered copy of `dir` |
| shoot_flag | output | 1 | High if either leg has both gates on |

## Verification
The bench builds the block with `DLY_W` = 4, `REFRESH_CYC` = 5 and `UPPER_HOLD_CYC` = 9. With these values the all-ones "never" code is 15, so it can be reached with ordinary stimulus. The whole release sequence, refresh followed by hold, fits in about a dozen cycles and can be repeated several times. Delay values of 0, 2 and 3 show the one-cycle turn-off against the longer turn-on. Reversing the direction for only two cycles lands inside a pending delay, which exercises the cancel-and-restart path.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  // Release sequence phases
  typedef enum logic [1:0] {
    PH_OFF     = 2'd0,
    PH_REFRESH = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RUN     = 2'd3
  } phase_t;

endpackage

// File: rtl/fbg_release_seq.sv
module fbg_release_seq
  import fbg_pkg::*;
#(
  parameter int REFRESH_CYC    = 32,
  parameter int UPPER_HOLD_CYC = 42
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   dis,
  output phase_t phase
);

  localparam int CW = $clog2(UPPER_HOLD_CYC + 1);
  localparam logic [CW-1:0] REF_LAST  = CW'(REFRESH_CYC - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(UPPER_HOLD_CYC - 1);

  logic [CW-1:0] pc;

  // Reset behaves like a fresh release: refresh pending
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_REFRESH;
      pc    <= '0;
    end else if (dis) begin
      phase <= PH_OFF;
      pc    <= '0;
    end else begin
      unique case (phase)
        PH_OFF: begin
          phase <= PH_REFRESH;
          pc    <= '0;
        end
        PH_REFRESH: begin
          if (pc == REF_LAST) phase <= PH_HOLD;
          pc <= pc + 1'b1;
        end
        PH_HOLD: begin
          if (pc == HOLD_LAST) phase <= PH_RUN;
          else                 pc    <= pc + 1'b1;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

endmodule

// File: rtl/fbg_gate_chan.sv
module fbg_gate_chan #(
  parameter int   DLY_W     = 8,
  parameter logic ALLOW_INF = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             force_off,
  input  logic             force_on,
  input  logic             req,
  input  logic [DLY_W-1:0] dly,
  output logic             gate
);

  localparam logic [DLY_W-1:0] SAT = '1;

  logic [DLY_W-1:0] cnt;
  logic             blocked;

  assign blocked = ALLOW_INF && (dly == SAT);

  // Turn-off immediate; turn-on after dly+1 consecutive request cycles
  always_ff @(posedge clk) begin
    if (rst || force_off) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else if (force_on) begin
      gate <= 1'b1;
      cnt  <= '0;
    end else if (!req) begin
      gate <= 1'b0;
      cnt  <= '0;
    end else begin
      gate <= !blocked && (cnt >= dly);
      if (cnt != SAT) cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/fbg_bridge_sequencer.sv
module fbg_bridge_sequencer
  import fbg_pkg::*;
#(
  parameter int DLY_W          = 8,
  parameter int REFRESH_CYC    = 32,
  parameter int UPPER_HOLD_CYC = 42
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dis,
  input  logic             hen,
  input  logic             dir,
  input  logic [DLY_W-1:0] hs_dly,
  input  logic [DLY_W-1:0] ls_dly,
  output logic             a_hi,
  output logic             a_lo,
  output logic             b_hi,
  output logic             b_lo,
  output logic             out_dir,
  output logic             shoot_flag
);

  localparam int LEGS = 2;

  phase_t          phase;
  logic            lower_off;
  logic            lower_force;
  logic            upper_off;
  logic [LEGS-1:0] hi_v;
  logic [LEGS-1:0] lo_v;

  fbg_release_seq #(
    .REFRESH_CYC   (REFRESH_CYC),
    .UPPER_HOLD_CYC(UPPER_HOLD_CYC)
  ) u_seq (
    .clk  (clk),
    .rst  (rst),
    .dis  (dis),
    .phase(phase)
  );

  assign lower_off   = dis || (phase == PH_OFF);
  assign lower_force = (phase == PH_REFRESH);
  assign upper_off   = dis || (phase != PH_RUN);

  // Leg 0 = A (upper on dir=1), leg 1 = B (upper on dir=0)
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic sel;
    assign sel = (g == 0) ? dir : ~dir;

    fbg_gate_chan #(.DLY_W(DLY_W), .ALLOW_INF(1'b0)) u_up (
      .clk      (clk),
      .rst      (rst),
      .force_off(upper_off),
      .force_on (1'b0),
      .req      (hen & sel),
      .dly      (hs_dly),
      .gate     (hi_v[g])
    );

    fbg_gate_chan #(.DLY_W(DLY_W), .ALLOW_INF(1'b1)) u_lo (
      .clk      (clk),
      .rst      (rst),
      .force_off(lower_off),
      .force_on (lower_force),
      .req      (~sel),
      .dly      (ls_dly),
      .gate     (lo_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_dir <= 1'b0;
    else     out_dir <= dir;
  end

  assign a_hi = hi_v[0];
  assign a_lo = lo_v[0];
  assign b_hi = hi_v[1];
  assign b_lo = lo_v[1];

  assign shoot_flag = |(hi_v & lo_v);

endmodule

// File: rtl/fbg_bridge_sequencer_chk.sv
module fbg_bridge_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic dis,
  input logic hen,
  input logic dir,
  input logic a_hi,
  input logic a_lo,
  input logic b_hi,
  input logic b_lo,
  input logic out_dir,
  input logic shoot_flag
);

  a_r1_dis_clears: assert property (@(posedge clk) disable iff (rst)
    dis |=> !(a_hi || a_lo || b_hi || b_lo));

  a_r4_hen_gates_upper: assert property (@(posedge clk) disable iff (rst)
    !hen |=> (!a_hi && !b_hi));

  a_r5_b_upper_off_fast: assert property (@(posedge clk) disable iff (rst)
    dir |=> !b_hi);

  a_r5_a_upper_off_fast: assert property (@(posedge clk) disable iff (rst)
    !dir |=> !a_hi);

  a_r7_refresh_after_release: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dis) && !dis) ##1 !dis |=> (a_lo && b_lo));

  a_r10_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(a_hi && a_lo) && !(b_hi && b_lo));

  a_r11_flag_low: assert property (@(posedge clk) disable iff (rst)
    !shoot_flag);

  a_r13_dir_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_dir == $past(dir)));

endmodule

bind fbg_bridge_sequencer fbg_bridge_sequencer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .dis       (dis),
  .hen       (hen),
  .dir       (dir),
  .a_hi      (a_hi),
  .a_lo      (a_lo),
  .b_hi      (b_hi),
  .b_lo      (b_lo),
  .out_dir   (out_dir),
  .shoot_flag(shoot_flag)
);

// File: tb/fbg_bridge_sequencer_bench.sv
module fbg_bridge_sequencer_bench;

  localparam int DW   = 4;
  localparam int REF  = 5;
  localparam int HOLD = 9;
  localparam int INF  = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dis = 1'b0, hen = 1'b1, dir = 1'b1;
  logic [DW-1:0] hs_dly = 4'd2, ls_dly = 4'd3;
  logic a_hi, a_lo, b_hi, b_lo, out_dir, shoot_flag;

  int checks = 0, fails = 0;
  string cur_req = "R12";
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fbg_bridge_sequencer #(
    .DLY_W(DW), .REFRESH_CYC(REF), .UPPER_HOLD_CYC(HOLD)
  ) u_fbg_bridge_sequencer (
    .clk(clk), .rst(rst), .dis(dis), .hen(hen), .dir(dir),
    .hs_dly(hs_dly), .ls_dly(ls_dly),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo),
    .out_dir(out_dir), .shoot_flag(shoot_flag)
  );

  // Reference model: ms 0 off, 1 refresh, 2 hold, 3 run
  int ms, mpc;
  int mcnt [4];
  bit mo [4];
  bit mdir;

  always @(posedge clk) begin
    bit req [4];
    bit up, off;
    int d;
    if (rst) begin
      ms = 1; mpc = 0; mdir = 0;
      for (int i = 0; i < 4; i++) begin mcnt[i] = 0; mo[i] = 0; end
    end else begin
      req[0] = hen && dir;  req[1] = !dir;
      req[2] = hen && !dir; req[3] = dir;
      for (int i = 0; i < 4; i++) begin
        up  = (i % 2 == 0);
        off = up ? (dis || ms != 3) : (dis || ms == 0);
        d   = up ? int'(hs_dly) : int'(ls_dly);
        if (off) begin mo[i] = 0; mcnt[i] = 0; end
        else if (!up && ms == 1) begin mo[i] = 1; mcnt[i] = 0; end
        else if (!req[i]) begin mo[i] = 0; mcnt[i] = 0; end
        else begin
          mo[i] = (up || d != INF) && (mcnt[i] >= d);
          if (mcnt[i] < INF) mcnt[i]++;
        end
      end
      mdir = dir;
      if (dis) begin ms = 0; mpc = 0; end
      else if (ms == 0) begin ms = 1; mpc = 0; end
      else if (ms == 1) begin if (mpc == REF - 1) ms = 2; mpc++; end
      else if (ms == 2) begin if (mpc == HOLD - 1) ms = 3; else mpc++; end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Advance one clock and compare against the model
  task automatic tick();
    int act, exp;
    @(negedge clk);
    act = {a_hi, a_lo, b_hi, b_lo, out_dir, shoot_flag};
    exp = {mo[0], mo[1], mo[2], mo[3], mdir, 1'b0};
    chk(cur_req, act, exp);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int t, first_both, first_ahi, both_cnt, lo_cnt, hi_cnt;
    // R12: reset state
    repeat (3) @(negedge clk);
    chk("R12", {a_hi, a_lo, b_hi, b_lo, out_dir}, 0);
    rst = 1'b0;
    // R12/R7/R8: post-reset refresh then delayed upper
    first_both = -1; first_ahi = -1; both_cnt = 0;
    for (int i = 0; i < 30; i++) begin
      tick();
      if (a_lo && b_lo) begin both_cnt++; if (first_both < 0) first_both = i; end
      if (a_hi && first_ahi < 0) first_ahi = i;
    end
    chk("R12", first_both, 0);
    chk("R7", both_cnt, REF);
    chk("R8", first_ahi - first_both, HOLD + 2);
    cur_req = "R2";
    chk("R2", {a_hi, a_lo, b_hi, b_lo}, 4'b1001);
    chk("R13", out_dir, 1);

    // R3/R5: reverse direction, measure delays
    cur_req = "R5";
    dir = 1'b0;
    tick();
    chk("R5", {a_hi, b_lo}, 0);
    t = 1;
    while (!b_hi && t < 20) begin tick(); t++; end
    chk("R5", t, 2 + 1);
    while (!a_lo && t < 20) begin tick(); t++; end
    chk("R5", t, 3 + 1);
    cur_req = "R3";
    ticks(4);
    chk("R3", {a_hi, a_lo, b_hi, b_lo}, 4'b0110);
    chk("R13", out_dir, 0);

    // R4: upper enable low, lowers still follow dir
    cur_req = "R4";
    hen = 1'b0;
    tick();
    chk("R4", {a_hi, b_hi, a_lo}, 3'b001);
    dir = 1'b1;
    ticks(6);
    chk("R4", {a_hi, a_lo, b_hi, b_lo}, 4'b0001);

    // R9: re-enable observes upper delay
    cur_req = "R9";
    hen = 1'b1;
    t = 0;
    while (!a_hi && t < 20) begin tick(); t++; end
    chk("R9", t, 2 + 1);

    // R10: short reversal cancels pending turn-ons
    cur_req = "R10";
    dir = 1'b0;
    hi_cnt = 0; lo_cnt = 0;
    for (int i = 0; i < 2; i++) begin tick(); hi_cnt += b_hi; lo_cnt += a_lo; end
    dir = 1'b1;
    for (int i = 0; i < 6; i++) begin tick(); hi_cnt += b_hi; lo_cnt += a_lo; end
    chk("R10", hi_cnt + lo_cnt, 0);
    chk("R10", {a_hi, b_lo}, 2'b11);

    // R1 and R7: disable then release
    cur_req = "R1";
    dis = 1'b1;
    tick();
    chk("R1", {a_hi, a_lo, b_hi, b_lo}, 0);
    dir = 1'b0; hen = 1'b1;
    ticks(3);
    chk("R1", {a_hi, a_lo, b_hi, b_lo}, 0);
    cur_req = "R7";
    dir = 1'b1;
    dis = 1'b0;
    tick();
    chk("R7", {a_lo, b_lo}, 0);
    tick();
    chk("R7", {a_lo, b_lo}, 2'b11);
    ticks(20);

    // R6: lower delay at its blocking code
    cur_req = "R6";
    ls_dly = 4'(INF);
    dis = 1'b1; tick(); dis = 1'b0;
    ticks(1 + REF);
    lo_cnt = 0; hi_cnt = 0;
    for (int k = 0; k < 4; k++) begin
      dir = ~dir;
      for (int i = 0; i < 25; i++) begin
        tick(); lo_cnt += a_lo + b_lo; hi_cnt += a_hi + b_hi;
      end
    end
    chk("R6", lo_cnt, 0);
    chk("R6", hi_cnt > 0, 1);

    // R11: zero delays, fast toggling
    cur_req = "R11";
    ls_dly = 4'd0; hs_dly = 4'd0;
    for (int i = 0; i < 40; i++) begin
      dir = (i % 3 == 0) ? ~dir : dir;
      hen = (i % 7 != 3);
      tick();
      chk("R11", shoot_flag, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule